// File: doc/BRIEF.md
# Multicast Address Table Host Reader

This block keeps four 48-bit multicast filter addresses and lets a host read or load them over a 32-bit bus. A host word written with the command flag set to read selects an entry. The host then drops an active-low read strobe for two cycles. The entry comes back as two registered 32-bit beats: the low word first, then the high word. The high word is zero-padded.

Loading uses the same write port. A command word with the flag clear names the target entry. The next two host writes carry the low and the high data words, in that order. The entry is updated only when the high word arrives. An index outside the table makes a read return zeros and makes a write leave every entry as it was.

Top module: `mcast_tbl_reader`

## Requirements
- R1: After reset, all four entries hold zero, the read index is 0 and `host_rdata_o` is zero.
- R2: A command word written with bit 31 = 0 and index bits [2:0] in 0..3 is followed by two data writes. The first data write supplies address bits [31:0]. The second supplies address bits [47:32] in its bits [15:0]. The entry is updated when the second data write arrives, and bits [31:16] of that write are ignored.
- R3: A command word written with bit 31 = 1 latches index bits [2:0] as the read index. Bits [30:3] are ignored, and no entry changes.
- R4: The first strobe-low cycle of a read makes `host_rdata_o` equal address bits [31:0] one clock later.
- R5: The second strobe-low cycle makes `host_rdata_o` equal {16'h0000, address bits [47:32]} one clock later.
- R6: While the strobe is high, `host_rdata_o` is zero one clock later. The next strobe-low cycle starts again with the low word.
- R7: A strobe held low for four cycles returns low, high, low, high words in turn.
- R8: A read index of 4..7 returns zero on both beats.
- R9: A write sequence with index 4..7 runs through its two data words but changes no entry.
- R10: An entry changes only when a write sequence for its own index completes. Read commands and strobe activity leave all entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for command and data words |
| host_wdata_i | input | 32 | Host write word |
| host_sel_ni | input | 1 | Active-low read strobe, two low cycles per entry |
| host_rdata_o | output | 32 | Registered read beat |

## Verification
Several properties are checked on every clock cycle:
- the read output drops to zero after any strobe-high cycle;
- the high beat always has a zero upper half;
- an out-of-range read index always yields zero;
- a low beat is always followed by a high beat while the strobe stays low;
- each entry is unchanged unless a write for its own index completes.

Other behaviour can only be shown by the bench's scenarios:
- that the correct 48-bit value is assembled from the low and high data words;
- that stray bits in command and data words have no effect;
- that an out-of-range write really leaves the stored table intact.

The bench shows these by reading every entry back through the strobe.

// File: rtl/mcast_pkg.sv
package mcast_pkg;
  localparam int ADDR_W = 48;
  localparam int DW     = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DW-1:0]     word_t;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_LO   = 2'd1,
    WS_HI   = 2'd2
  } wr_st_e;
endpackage

// File: rtl/mcast_cmd_dec.sv
module mcast_cmd_dec
  import mcast_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3,
  parameter int RNW_BIT = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  word_t            wdata_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             commit_o,
  output logic [IDX_W-1:0] commit_idx_o,
  output addr_t            commit_data_o
);
  localparam logic [IDX_W:0] ENT_L = ENTRIES[IDX_W:0];
  localparam int HI_W = ADDR_W - DW;

  wr_st_e           st_q;
  logic [IDX_W-1:0] rd_idx_q, wr_idx_q;
  word_t            lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= WS_IDLE;
      rd_idx_q <= '0;
      wr_idx_q <= '0;
      lo_q     <= '0;
    end else if (wr_i) begin
      unique case (st_q)
        WS_IDLE: begin
          if (wdata_i[RNW_BIT]) begin
            rd_idx_q <= wdata_i[IDX_W-1:0];
          end else begin
            wr_idx_q <= wdata_i[IDX_W-1:0];
            st_q     <= WS_LO;
          end
        end
        WS_LO: begin
          lo_q <= wdata_i;
          st_q <= WS_HI;
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  // commit only on the high word and only for a valid slot
  assign commit_o      = wr_i && (st_q == WS_HI) && ({1'b0, wr_idx_q} < ENT_L);
  assign commit_idx_o  = wr_idx_q;
  assign commit_data_o = {wdata_i[HI_W-1:0], lo_q};
  assign rd_idx_o      = rd_idx_q;
endmodule

// File: rtl/mcast_store.sv
module mcast_store
  import mcast_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  addr_t            wdata_i,
  output addr_t            tbl_o [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    addr_t ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        ent_q <= '0;
      else if (we_i && widx_i == MY_IDX)  ent_q <= wdata_i;
    end

    assign tbl_o[g] = ent_q;
  end
endmodule

// File: rtl/mcast_rd_seq.sv
module mcast_rd_seq
  import mcast_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  addr_t            tbl_i [ENTRIES],
  output word_t            rdata_o,
  output logic             beat_o
);
  localparam int PAD_W = 2*DW - ADDR_W;

  logic  beat_q;
  addr_t ent;
  word_t word;
  word_t rdata_q;

  // out-of-range index falls through to zero
  always_comb begin
    ent = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx_i == IDX_W'(i)) ent = tbl_i[i];
    end
  end

  assign word = beat_q ? {{PAD_W{1'b0}}, ent[ADDR_W-1:DW]} : ent[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= 1'b0;
      rdata_q <= '0;
    end else if (sel_ni) begin
      beat_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      beat_q  <= ~beat_q;
      rdata_q <= word;
    end
  end

  assign rdata_o = rdata_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/mcast_tbl_reader.sv
module mcast_tbl_reader
  import mcast_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3,
  parameter int RNW_BIT = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_wr_i,
  input  logic [31:0] host_wdata_i,
  input  logic        host_sel_ni,
  output logic [31:0] host_rdata_o
);
  logic [IDX_W-1:0] rd_idx;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  addr_t            commit_data;
  addr_t            tbl [ENTRIES];
  logic             beat;

  mcast_cmd_dec #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .RNW_BIT (RNW_BIT)
  ) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (host_wr_i),
    .wdata_i       (host_wdata_i),
    .rd_idx_o      (rd_idx),
    .commit_o      (commit),
    .commit_idx_o  (commit_idx),
    .commit_data_o (commit_data)
  );

  mcast_store #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .widx_i  (commit_idx),
    .wdata_i (commit_data),
    .tbl_o   (tbl)
  );

  mcast_rd_seq #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_ni  (host_sel_ni),
    .idx_i   (rd_idx),
    .tbl_i   (tbl),
    .rdata_o (host_rdata_o),
    .beat_o  (beat)
  );
endmodule

// File: rtl/mcast_tbl_reader_chk.sv
module mcast_tbl_reader_chk
  import mcast_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_sel_ni,
  input logic [31:0]      host_rdata_o,
  input logic             beat,
  input logic [IDX_W-1:0] rd_idx,
  input logic             commit,
  input logic [IDX_W-1:0] commit_idx,
  input addr_t            tbl [ENTRIES]
);
  localparam logic [IDX_W:0] ENT_L = ENTRIES[IDX_W:0];

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_sel_ni |=> host_rdata_o == '0);                               // R6

  AST_HI_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_sel_ni && beat) |=> host_rdata_o[31:16] == 16'h0000);       // R5

  AST_PAIR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_sel_ni && !beat) |=> beat);                                 // R7

  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_sel_ni && ({1'b0, rd_idx} >= ENT_L)) |=> host_rdata_o == '0); // R8

  for (genvar g = 0; g < ENTRIES; g++) begin : g_hold
    AST_ENTRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(commit && commit_idx == IDX_W'(g)) |=> $stable(tbl[g]));       // R10
  end
endmodule

bind mcast_tbl_reader mcast_tbl_reader_chk #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_sel_ni  (host_sel_ni),
  .host_rdata_o (host_rdata_o),
  .beat         (beat),
  .rd_idx       (rd_idx),
  .commit       (commit),
  .commit_idx   (commit_idx),
  .tbl          (tbl)
);

// File: tb/mcast_tbl_reader_test.sv
module mcast_tbl_reader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        sel_n = 1'b1;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mcast_tbl_reader uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_wr_i    (wr),
    .host_wdata_i (wdata),
    .host_sel_ni  (sel_n),
    .host_rdata_o (rdata)
  );

  localparam logic [47:0] A0 = 48'h0123_4567_89AB;
  localparam logic [47:0] A1 = 48'hFFFF_0000_FFFF;
  localparam logic [47:0] A2 = 48'h8000_0000_0001;
  localparam logic [47:0] A3 = 48'hA5A5_5A5A_C3C3;

  typedef struct packed {
    logic [2:0]  idx;
    logic [47:0] addr;
  } vec_t;

  // idx 5 and 7 are out of range (R8)
  localparam vec_t VECS [7] = '{
    '{3'd0, A0}, '{3'd1, A1}, '{3'd2, A2}, '{3'd3, A3},
    '{3'd5, 48'h0}, '{3'd7, 48'h0}, '{3'd2, A2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic host_write(input logic [31:0] w);
    wr    = 1'b1;
    wdata = w;
    @(negedge clk);
    wr    = 1'b0;
    wdata = '0;
  endtask

  task automatic load_entry(input logic [2:0] idx, input logic [47:0] a);
    host_write({1'b0, 28'h5A5A5A5, idx});
    host_write(a[31:0]);
    host_write({16'hDEAD, a[47:32]});
  endtask

  task automatic read_entry(input logic [2:0] idx, input logic [47:0] a, input string tag);
    host_write({1'b1, 28'h1234567, idx});
    sel_n = 1'b0;
    @(negedge clk);
    chk({tag, " R4 low beat"}, rdata, a[31:0]);
    @(negedge clk);
    chk({tag, " R5 high beat"}, rdata, {16'h0000, a[47:32]});
    sel_n = 1'b1;
    @(negedge clk);
    chk({tag, " R6 idle zero"}, rdata, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 rdata after reset", rdata, 32'h0);
    read_entry(3'd0, 48'h0, "R1 entry0 cleared");
    read_entry(3'd3, 48'h0, "R1 entry3 cleared");

    // R2: load all entries, junk in command and high-word upper bits
    load_entry(3'd0, A0);
    load_entry(3'd1, A1);
    load_entry(3'd2, A2);
    load_entry(3'd3, A3);

    for (int i = 0; i < 7; i++) begin
      read_entry(VECS[i].idx, VECS[i].addr, $sformatf("R2/R3/R8 vec%0d", i));
    end

    // R7: strobe held four cycles
    host_write({1'b1, 28'h0, 3'd1});
    sel_n = 1'b0;
    @(negedge clk); chk("R7 beat1 low",  rdata, A1[31:0]);
    @(negedge clk); chk("R7 beat2 high", rdata, {16'h0, A1[47:32]});
    @(negedge clk); chk("R7 beat3 low",  rdata, A1[31:0]);
    @(negedge clk); chk("R7 beat4 high", rdata, {16'h0, A1[47:32]});
    sel_n = 1'b1;
    @(negedge clk); chk("R6 after hold", rdata, 32'h0);

    // R6: strobe released after one low cycle restarts at the low word
    host_write({1'b1, 28'h0, 3'd3});
    sel_n = 1'b0;
    @(negedge clk); chk("R6 first low", rdata, A3[31:0]);
    sel_n = 1'b1;
    @(negedge clk); chk("R6 released", rdata, 32'h0);
    sel_n = 1'b0;
    @(negedge clk); chk("R6 restart low", rdata, A3[31:0]);
    sel_n = 1'b1;
    @(negedge clk);

    // R9: out-of-range write leaves the table intact
    load_entry(3'd6, 48'h1111_2222_3333);
    load_entry(3'd4, 48'h4444_5555_6666);
    read_entry(3'd0, A0, "R9 entry0");
    read_entry(3'd1, A1, "R9 entry1");
    read_entry(3'd2, A2, "R9 entry2");
    read_entry(3'd3, A3, "R9 entry3");

    // R10: overwrite one entry, others unchanged
    load_entry(3'd2, 48'h0F0F_F0F0_1234);
    read_entry(3'd2, 48'h0F0F_F0F0_1234, "R10 rewritten");
    read_entry(3'd1, A1, "R10 neighbour");
    read_entry(3'd3, A3, "R10 neighbour");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule